// File: doc/BRIEF.md
# Serial Master Port with Variable-Length Units

This block is a serial peripheral master in clock mode 0. Software reaches it through a small register window: one register receives transmit words and hands back received words, one holds the two unit-length codes and shows the status flags, one holds the interrupt enables, the clock divider and the block-done flag, and one sets the unit count for a block. Transmit words wait in a small FIFO. The shift engine takes each word in turn and clocks it out. A word captured from the slave goes into a second FIFO until software reads it.

The number of bits in each unit is set separately for transmit and for receive, from one bit up to a full word. One unit runs for as many serial clocks as the longer of the two lengths. For the first transmit-length clocks the output line carries the low transmit-length bits of the word, most significant first, and after that it is driven low. Only the first receive-length samples are kept. They are right-aligned, and the upper bits of the received word are zero. A new unit starts only when the receive FIFO has room, so a captured unit is never dropped. Three maskable interrupt lines report transmit FIFO empty, receive data waiting and the end of a programmed block of units.

Top module: `spi_partial_port`

## Requirements
- R1: A transmit length code in cfg bits [5:3] of 000 means 8 bits, and 001 to 111 mean that many bits. A unit lasts max(transmit bits, receive bits) rising SCLK edges. MOSI carries word bits [T-1:0], MSB first, and is then 0 for the rest of the unit.
- R2: A receive length code in cfg bits [2:0] of 000 means 8 bits, and 001 to 111 mean that many bits. The first R samples of MISO, taken on rising SCLK edges, are read back from the data register (address 0) in bits [R-1:0], first sample highest, with all other bits 0.
- R3: Cfg register (address 1) bit 8 reads 1 exactly when the receive FIFO holds unread data.
- R4: Cfg register bit 7 reads 1 exactly when the transmit FIFO is empty.
- R5: Cfg register bit 6 reads 1 exactly when the receive FIFO is full. No unit starts while it is full.
- R6: A write to the data register while the transmit FIFO is full is ignored. A read of the data register with rd_en while the receive FIFO is empty is ignored. In both cases the FIFO contents and order are unchanged.
- R7: The interrupt register (address 2) holds the enables: bit 0 for block done, bit 1 for transmit and bit 2 for receive. All three reset to 0. irq_tx equals bit 1 AND transmit FIFO empty, and irq_rx equals bit 2 AND receive data waiting.
- R8: A write to address 3 loads a unit count in bits [7:0] and arms the block counter. Once that many units have completed and the transmit side is idle and empty, interrupt-register bit 3 is set. It stays set until a write to address 2 with bit 3 = 1 clears it. irq_blk equals enable bit 0 AND bit 3.
- R9: SCLK idles low. Each SCLK half period lasts D+1 system clocks, where D is interrupt-register bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; pops the receive FIFO when addr is 0 |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| irq_rx | output | 1 | Receive data interrupt |
| irq_tx | output | 1 | Transmit empty interrupt |
| irq_blk | output | 1 | Block complete interrupt |

## Verification
Two things can fall in the same cycle. Software can pop the receive FIFO in the cycle the engine pushes a finished unit into it, and the engine can take a transmit word in the cycle software's read frees the room it was waiting for. To provoke both, the bench fills the receive FIFO, queues a full transmit FIFO behind it and then reads the receive words back while the queued units start and complete. The result is judged by the exact MOSI bit stream of the queued words, the total count of SCLK edges and the data read back afterwards. A fifth queued word must not appear, and no captured unit may be lost or duplicated.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_CFG  = 2'd1,
      RA_IRQ  = 2'd2,
      RA_BLK  = 2'd3
   } reg_addr_e;

   localparam int REG_W = 16;
endpackage

// File: rtl/spi_pp_fifo.sv
module spi_pp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] pdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("spi_pp_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         if (do_push && !do_pop)      count <= count + CW'(1);
         else if (do_pop && !do_push) count <= count - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= pdata;
   end

   // R6
   fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wptr) && $stable(rptr)));
endmodule

// File: rtl/spi_pp_engine.sv
module spi_pp_engine #(
   parameter int W    = 8,
   parameter int DIVW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [W-1:0]          tx_word,
   input  logic [$clog2(W)-1:0]  tx_code,
   input  logic [$clog2(W)-1:0]  rx_code,
   input  logic [DIVW-1:0]       div,
   input  logic                  miso,
   output logic                  sclk,
   output logic                  mosi,
   output logic                  busy,
   output logic                  done,
   output logic [W-1:0]          rx_word
);
   localparam int LW = $clog2(W);
   localparam int BW = LW + 1;

   if ((1 << LW) != W || W < 2) begin : g_bad_w
      $error("spi_pp_engine: W must be a power of two of at least 2");
   end

   function automatic logic [BW-1:0] bits_of(input logic [LW-1:0] code);
      return (code == '0) ? BW'(W) : BW'(code);
   endfunction

   logic [BW-1:0]   tb, rb, t_n, r_n, n_bits, bitcnt;
   logic [DIVW-1:0] cnt;
   logic [W-1:0]    txsh, rxsh;

   assign tb      = bits_of(tx_code);
   assign rb      = bits_of(rx_code);
   assign mosi    = busy && txsh[W-1] && (bitcnt < t_n);
   assign rx_word = rxsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sclk   <= 1'b0;
         done   <= 1'b0;
         cnt    <= '0;
         bitcnt <= '0;
         t_n    <= '0;
         r_n    <= '0;
         n_bits <= '0;
         txsh   <= '0;
         rxsh   <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               cnt    <= '0;
               bitcnt <= '0;
               t_n    <= tb;
               r_n    <= rb;
               n_bits <= (tb > rb) ? tb : rb;
               txsh   <= tx_word << (BW'(W) - tb);
               rxsh   <= '0;
            end
         end else if (cnt >= div) begin
            cnt <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
               if (bitcnt < r_n) rxsh <= {rxsh[W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitcnt == n_bits - BW'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + BW'(1);
                  txsh   <= {txsh[W-2:0], 1'b0};
               end
            end
         end else begin
            cnt <= cnt + DIVW'(1);
         end
      end
   end

   // R9
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
endmodule

// File: rtl/spi_partial_port.sv
module spi_partial_port
   import spi_pp_pkg::*;
#(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int DIVW  = 8,
   parameter int CNTW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_blk
);
   localparam int LW = $clog2(W);

   if (W > 8 || DIVW > 8 || CNTW > 16) begin : g_bad_map
      $error("spi_partial_port: parameters do not fit the register layout");
   end

   logic [LW-1:0]   tx_code, rx_code;
   logic [DIVW-1:0] div;
   logic [2:0]      irq_en;
   logic [CNTW-1:0] blk_left;
   logic            blk_armed, blk_pend;
   logic [W-1:0]    tx_head, rx_head, rx_word;
   logic            tx_empty, tx_full, rx_empty, rx_full;
   logic            busy, done, start;
   logic            wr_data, rd_data, wr_cfg, wr_irq, wr_blk;
   reg_addr_e       ra;

   assign ra      = reg_addr_e'(addr);
   assign wr_data = wr_en && (ra == RA_DATA);
   assign wr_cfg  = wr_en && (ra == RA_CFG);
   assign wr_irq  = wr_en && (ra == RA_IRQ);
   assign wr_blk  = wr_en && (ra == RA_BLK);
   assign rd_data = rd_en && (ra == RA_DATA);
   assign start   = !busy && !done && !tx_empty && !rx_full;

   spi_pp_fifo #(.W(W), .DEPTH(DEPTH)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_data), .pdata(wdata[W-1:0]),
      .pop(start), .head(tx_head), .empty(tx_empty), .full(tx_full));

   spi_pp_fifo #(.W(W), .DEPTH(DEPTH)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .push(done), .pdata(rx_word),
      .pop(rd_data), .head(rx_head), .empty(rx_empty), .full(rx_full));

   spi_pp_engine #(.W(W), .DIVW(DIVW)) i_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_head),
      .tx_code(tx_code), .rx_code(rx_code), .div(div), .miso(miso),
      .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code   <= '0;
         rx_code   <= '0;
         div       <= '0;
         irq_en    <= '0;
         blk_left  <= '0;
         blk_armed <= 1'b0;
         blk_pend  <= 1'b0;
      end else begin
         if (wr_cfg) begin
            tx_code <= wdata[3 +: LW];
            rx_code <= wdata[0 +: LW];
         end
         if (wr_irq) begin
            irq_en <= wdata[2:0];
            div    <= wdata[8 +: DIVW];
         end
         if (wr_blk) begin
            blk_left  <= wdata[0 +: CNTW];
            blk_armed <= 1'b1;
         end else if (blk_armed) begin
            if (done && blk_left != '0) begin
               blk_left <= blk_left - CNTW'(1);
            end else if (blk_left == '0 && tx_empty && !busy && !done) begin
               blk_pend  <= 1'b1;
               blk_armed <= 1'b0;
            end
         end
         if (wr_irq && wdata[3]) blk_pend <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (ra)
         RA_DATA: rdata[W-1:0] = rx_head & {W{!rx_empty}};
         RA_CFG: begin
            rdata[8]       = !rx_empty;
            rdata[7]       = tx_empty;
            rdata[6]       = rx_full;
            rdata[3 +: LW] = tx_code;
            rdata[0 +: LW] = rx_code;
         end
         RA_IRQ: begin
            rdata[2:0]       = irq_en;
            rdata[3]         = blk_pend;
            rdata[8 +: DIVW] = div;
         end
         RA_BLK: rdata[0 +: CNTW] = blk_left;
         default: rdata = '0;
      endcase
   end

   assign irq_tx  = irq_en[1] && tx_empty;
   assign irq_rx  = irq_en[2] && !rx_empty;
   assign irq_blk = irq_en[0] && blk_pend;

   // R5
   rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rx_full);

   // R8
   blk_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blk_pend) |-> (tx_empty && !busy));

   // R6
   tx_unchanged_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !start) |=> !tx_empty);
endmodule

// File: tb/test_spi_partial_port.sv
module test_spi_partial_port;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        sclk, mosi, miso = 1'b0;
   logic        irq_rx, irq_tx, irq_blk;

   int errors = 0, checks = 0;
   int cyc = 0, t_last = 0, t_prev = 0;
   int edges = 0, sidx = 0;
   logic [7:0]  sw = '0;
   logic [31:0] mlog = '0;

   spi_partial_port i_spi_partial_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
      .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_blk(irq_blk));

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc++;

   always @(posedge sclk) begin
      edges++;
      mlog   = {mlog[30:0], mosi};
      t_prev = t_last;
      t_last = cyc;
   end
   always @(negedge sclk) begin
      sidx++;
      miso = sw[7 - (sidx % 8)];
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic pop, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
      rd_en = pop;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic prep_slave(input logic [7:0] v);
      sw = v; sidx = 0; miso = v[7]; edges = 0; mlog = '0;
   endtask

   task automatic wait_ready();
      logic [15:0] s;
      for (int i = 0; i < 500; i++) begin
         rd(2'd1, 1'b0, s);
         if (s[8]) break;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: R3 R4 R5 R7
      rd(2'd1, 1'b0, v);
      chk("R4 reset status", v, 16'h0080);
      rd(2'd2, 1'b0, v);
      chk("R7 enables reset", v, 0);
      chk("R7 irq lines after reset", {irq_rx, irq_tx, irq_blk}, 0);
      // R6: pop of empty receive FIFO ignored
      rd(2'd0, 1'b1, v);
      rd(2'd1, 1'b0, v);
      chk("R6 empty pop ignored", v[8], 0);

      // sweep every length pair, divider 0
      wr(2'd2, 16'h0000);
      for (int t = 0; t < 8; t++) begin
         for (int r = 0; r < 8; r++) begin
            int tb, rbits, n;
            logic [7:0] d, s;
            tb = (t == 0) ? 8 : t;
            rbits = (r == 0) ? 8 : r;
            n = (tb > rbits) ? tb : rbits;
            d = 8'((t * 37 + r * 11 + 5) & 255);
            s = 8'((t * 53 + r * 29 + 150) & 255);
            wr(2'd1, 16'((t << 3) | r));
            prep_slave(s);
            wr(2'd0, {8'h00, d});
            wait_ready();
            rd(2'd0, 1'b1, v);
            chk($sformatf("R2 rx t=%0d r=%0d", t, r), v, int'(s) >> (8 - rbits));
            chk($sformatf("R1 edges t=%0d r=%0d", t, r), edges, n);
            chk($sformatf("R1 mosi t=%0d r=%0d", t, r),
                int'(mlog) & ((1 << n) - 1),
                (int'(d) & ((1 << tb) - 1)) << (n - tb));
         end
      end

      // fill receive FIFO, then queue a full transmit FIFO behind it
      wr(2'd1, 16'h0000);
      prep_slave(8'h5A);
      for (int k = 0; k < 4; k++) begin
         wr(2'd0, 16'(8'h40 + k));
         repeat (30) @(negedge clk);
      end
      rd(2'd1, 1'b0, v);
      chk("R5 rx full flag", v[8:6], 3'b111);
      chk("R3 ready while full", v[8], 1);
      prep_slave(8'h5A);
      for (int k = 0; k < 5; k++) wr(2'd0, 16'(8'h10 + k));
      repeat (40) @(negedge clk);
      chk("R5 no unit while rx full", edges, 0);
      rd(2'd1, 1'b0, v);
      chk("R4 tx not empty", v[7], 0);
      for (int k = 0; k < 4; k++) begin
         rd(2'd0, 1'b1, v);
         chk("R2 fill data", v, 16'h005A);
      end
      repeat (200) @(negedge clk);
      chk("R6 fifth word ignored edges", edges, 32);
      chk("R6 queued order on mosi", mlog, 32'h10111213);
      for (int k = 0; k < 4; k++) begin
         rd(2'd0, 1'b1, v);
         chk("R2 drained data", v, 16'h005A);
      end
      rd(2'd1, 1'b0, v);
      chk("R3 R4 empty after drain", v[8:6], 3'b010);

      // interrupts
      wr(2'd2, 16'h0002);
      @(negedge clk);
      chk("R7 irq_tx", {irq_rx, irq_tx, irq_blk}, 3'b010);
      wr(2'd2, 16'h0006);
      prep_slave(8'h81);
      wr(2'd0, 16'h0033);
      wait_ready();
      chk("R7 irq_rx set", irq_rx, 1);
      rd(2'd0, 1'b1, v);
      #1 chk("R7 irq_rx clear", irq_rx, 0);
      wr(2'd2, 16'h0001);
      wr(2'd3, 16'h0003);
      wr(2'd0, 16'h0001);
      wr(2'd0, 16'h0002);
      repeat (80) @(negedge clk);
      chk("R8 not yet pending", irq_blk, 0);
      wr(2'd0, 16'h0003);
      repeat (60) @(negedge clk);
      chk("R8 irq_blk set", irq_blk, 1);
      rd(2'd2, 1'b0, v);
      chk("R8 pending bit", v[3], 1);
      wr(2'd2, 16'h0009);
      @(negedge clk);
      chk("R8 cleared by write", irq_blk, 0);
      for (int k = 0; k < 3; k++) rd(2'd0, 1'b1, v);

      // divider
      wr(2'd2, 16'h0200);
      prep_slave(8'hF0);
      wr(2'd0, 16'h00C3);
      wait_ready();
      chk("R9 sclk period", t_last - t_prev, 6);
      chk("R9 sclk idle low", sclk, 0);
      rd(2'd0, 1'b1, v);
      chk("R9 data at divider 2", v, 16'h00F0);

      finish_run();
   end
endmodule